// File: doc/BRIEF.md
# I2C Combined-Transaction Master Sequencer

This block is the bus-facing engine of an I2C controller. Each accepted start strobe runs one transaction. The transaction is a plain write, a plain read, or a write followed by a read to the same target, with a repeated start between the two phases. Setup values are held on register-style inputs: the 7-bit target address, a primary and an auxiliary byte count, a transaction count, a direction-change enable, a read select for single-direction transfers and an interrupt enable mask. Write data is taken from a byte source through a pop strobe. Read data is delivered to a byte sink through a valid strobe.

The open-drain lines are controlled by active-high pull-down enables. Each bit slot lasts four quarter-phases, and an external bit-timing tick advances the quarter-phase. The outcome is recorded in three sticky status bits: completion, acknowledge error and a high-speed NACK error. This engine never sets the high-speed bit, but software can clear it like the others. A two-bit result code reports the highest-priority status bit that is set, and the interrupt output is raised by any status bit whose enable is set.

Top module: `i2c_xact_seq`

## Requirements
- R1: In write mode the bus carries a start, the address byte `{tgt_addr,0}`, then `len_pri` bytes taken from `tx_data`, then a stop. Exactly one `tx_pop` pulse is issued per data byte. On success `status[0]` (done) is set.
- R2: In read mode the bus carries a start, the address byte `{tgt_addr,1}`, then `len_pri` bytes delivered on `rx_data` with `rx_valid`, then a stop. The master ACKs every byte except the last, which it NACKs.
- R3: When `xact_cnt==2` and `dir_chg_en==1` the mode is combined. The engine writes `len_pri` bytes, issues a repeated start with no stop, sends `{tgt_addr,1}` and reads `len_aux` bytes. Any other setting gives a single-direction transfer chosen by `rd_sel`.
- R4: A start strobe is rejected when `len_pri==0`, or when the mode is combined and `len_aux==0`. In that case `busy` stays low, the lines stay released and the status does not change.
- R5: A NACK after an address byte or a write byte ends the transaction with a stop and sets `status[1]` (ack error). No further byte is popped and done is not set.
- R6: `busy` rises in the cycle after an accepted start strobe and falls when the stop finishes, at which point both lines are released. A start strobe that arrives while busy has no effect.
- R7: Writing 1 to a bit of `stat_clr` clears that status bit. All other status bits keep their value.
- R8: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.
- R9: `res_code` is 3 if `status[2]` is set, otherwise 2 if `status[1]` is set, otherwise 1 if `status[0]` is set, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Quarter-bit advance strobe |
| go | input | 1 | Start strobe |
| rd_sel | input | 1 | Read select for single-direction mode |
| tgt_addr | input | 7 | Target address |
| len_pri | input | 8 | Write count, or read count in read mode |
| len_aux | input | 8 | Read count of the combined mode |
| xact_cnt | input | 2 | Transaction count (2 selects combined when enabled) |
| dir_chg_en | input | 1 | Direction-change enable |
| irq_en | input | 3 | Interrupt enable per status bit |
| stat_clr | input | 3 | Write-1-to-clear strobes for status |
| tx_data | input | 8 | Current byte of the TX source |
| tx_pop | output | 1 | TX byte consumed |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte valid |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_oe | output | 1 | SDA pull-down enable |
| busy | output | 1 | Transaction in progress |
| status | output | 3 | Sticky status: [0] done, [1] ack error, [2] high-speed NACK |
| res_code | output | 2 | Prioritised status code |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the repeated start of the combined mode. A design that placed a stop there, or resent the write address, would show up as an extra stop or as a wrong address byte in the target model's start/stop counts. It checks the master's ACK/NACK on every read byte: a design that ACKed the last byte would keep the target driving data and corrupt the stop. It also injects NACKs on the address and on a middle write byte, where a design that kept going would pop extra TX bytes or set done. Finally it sends zero-length and mid-transfer start strobes, and checks the priority code with done and ack error both set.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_RSTART,
        ST_STOP
    } seq_st_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_WR,
        BK_RD
    } byte_kind_e;

    localparam int STAT_W      = 3;
    localparam int STAT_DONE   = 0;
    localparam int STAT_ACKERR = 1;
    localparam int STAT_HSNACK = 2;
endpackage

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [LEN_W-1:0]  len_pri,
    input  logic [LEN_W-1:0]  len_aux,
    input  logic [CNT_W-1:0]  xact_cnt,
    input  logic              dir_chg_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sda_in,
    output logic              tx_pop,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              set_done,
    output logic              set_err,
    output seq_st_e           st,
    output logic [1:0]        ph,
    output logic              in_ack,
    output byte_kind_e        kind,
    output logic              bit_out,
    output logic              rd_ack
);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        ph;
        logic [BIT_W-1:0]  bidx;
        byte_kind_e        kind;
        logic [DATA_W-1:0] sh;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  lp;
        logic [LEN_W-1:0]  la;
        logic [ADDR_W-1:0] addr;
        logic              combo;
        logic              rdp;
        logic              nack;
        logic              err;
    } ctrl_t;

    ctrl_t q, d;
    logic  combo_in, lens_ok, last;

    always_comb begin
        d        = q;
        tx_pop   = 1'b0;
        rx_valid = 1'b0;
        set_done = 1'b0;
        set_err  = 1'b0;
        combo_in = (xact_cnt == CNT_W'(2)) && dir_chg_en;
        lens_ok  = (len_pri != '0) && (!combo_in || (len_aux != '0));
        last     = (q.cnt == LEN_W'(1));
        if (q.st == ST_IDLE) begin
            if (go && lens_ok) begin
                d.st    = ST_START;
                d.ph    = 2'd0;
                d.addr  = tgt_addr;
                d.lp    = len_pri;
                d.la    = len_aux;
                d.combo = combo_in;
                d.rdp   = combo_in ? 1'b0 : rd_sel;
                d.nack  = 1'b0;
                d.err   = 1'b0;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            // sample point: end of the SCL high half
            if (q.st == ST_BIT && q.ph == 2'd2) begin
                if (q.bidx != ACK_SLOT && q.kind == BK_RD)
                    d.sh = {q.sh[DATA_W-2:0], sda_in};
                if (q.bidx == ACK_SLOT)
                    d.nack = sda_in;
            end
            if (q.ph == 2'd3) begin
                case (q.st)
                    ST_START, ST_RSTART: begin
                        d.st   = ST_BIT;
                        d.bidx = '0;
                        d.kind = BK_ADDR;
                        d.sh   = DATA_W'({q.addr, q.rdp});
                    end
                    ST_BIT: begin
                        if (q.bidx != ACK_SLOT) begin
                            d.bidx = q.bidx + BIT_W'(1);
                            if (q.kind != BK_RD) d.sh = q.sh << 1;
                        end else begin
                            d.bidx = '0;
                            if (q.kind != BK_RD && q.nack) begin
                                d.err = 1'b1;
                                d.st  = ST_STOP;
                            end else begin
                                case (q.kind)
                                    BK_ADDR: begin
                                        if (q.rdp) begin
                                            d.kind = BK_RD;
                                            d.cnt  = q.combo ? q.la : q.lp;
                                        end else begin
                                            d.kind = BK_WR;
                                            d.cnt  = q.lp;
                                            d.sh   = tx_data;
                                            tx_pop = 1'b1;
                                        end
                                    end
                                    BK_WR: begin
                                        if (last) begin
                                            if (q.combo) begin
                                                d.st  = ST_RSTART;
                                                d.rdp = 1'b1;
                                            end else begin
                                                d.st = ST_STOP;
                                            end
                                        end else begin
                                            d.cnt  = q.cnt - LEN_W'(1);
                                            d.sh   = tx_data;
                                            tx_pop = 1'b1;
                                        end
                                    end
                                    default: begin
                                        rx_valid = 1'b1;
                                        if (last) d.st = ST_STOP;
                                        else      d.cnt = q.cnt - LEN_W'(1);
                                    end
                                endcase
                            end
                        end
                    end
                    ST_STOP: begin
                        d.st     = ST_IDLE;
                        set_done = !q.err;
                        set_err  = q.err;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= BK_ADDR;
        end else begin
            q <= d;
        end
    end

    assign rx_data = q.sh;
    assign busy    = (q.st != ST_IDLE);
    assign st      = q.st;
    assign ph      = q.ph;
    assign in_ack  = (q.bidx == ACK_SLOT);
    assign kind    = q.kind;
    assign bit_out = q.sh[DATA_W-1];
    assign rd_ack  = !last;
endmodule

// File: rtl/i2c_seq_line.sv
module i2c_seq_line
    import i2c_seq_pkg::*;
(
    input  seq_st_e    st,
    input  logic [1:0] ph,
    input  logic       in_ack,
    input  byte_kind_e kind,
    input  logic       bit_out,
    input  logic       rd_ack,
    output logic       scl_oe,
    output logic       sda_oe
);
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (st)
            ST_START: begin
                sda_oe = (ph != 2'd0);
                scl_oe = (ph == 2'd3);
            end
            ST_BIT: begin
                scl_oe = (ph == 2'd0) || (ph == 2'd3);
                if (in_ack) sda_oe = (kind == BK_RD) ? rd_ack : 1'b0;
                else        sda_oe = (kind == BK_RD) ? 1'b0 : !bit_out;
            end
            ST_RSTART: begin
                scl_oe = (ph == 2'd0) || (ph == 2'd3);
                sda_oe = ph[1];
            end
            ST_STOP: begin
                scl_oe = (ph == 2'd0);
                sda_oe = (ph[1] == 1'b0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_seq_stat.sv
module i2c_seq_stat
    import i2c_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_done,
    input  logic              set_err,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic [STAT_W-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic [1:0]        res_code,
    output logic              irq
);
    logic [STAT_W-1:0] stat_q, stat_d, set_vec;

    always_comb begin
        set_vec              = '0;
        set_vec[STAT_DONE]   = set_done;
        set_vec[STAT_ACKERR] = set_err;
        stat_d               = (stat_q & ~stat_clr) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    always_comb begin
        if      (stat_q[STAT_HSNACK]) res_code = 2'd3;
        else if (stat_q[STAT_ACKERR]) res_code = 2'd2;
        else if (stat_q[STAT_DONE])   res_code = 2'd1;
        else                          res_code = 2'd0;
    end

    assign status = stat_q;
    assign irq    = |(stat_q & irq_en);
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [LEN_W-1:0]  len_pri,
    input  logic [LEN_W-1:0]  len_aux,
    input  logic [CNT_W-1:0]  xact_cnt,
    input  logic              dir_chg_en,
    input  logic [STAT_W-1:0] irq_en,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic [STAT_W-1:0] status,
    output logic [1:0]        res_code,
    output logic              irq
);
    seq_st_e    st;
    byte_kind_e kind;
    logic [1:0] ph;
    logic       in_ack, bit_out, rd_ack, set_done, set_err;

    i2c_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .rd_sel(rd_sel),
        .tgt_addr(tgt_addr), .len_pri(len_pri), .len_aux(len_aux),
        .xact_cnt(xact_cnt), .dir_chg_en(dir_chg_en), .tx_data(tx_data),
        .sda_in(sda_in), .tx_pop(tx_pop), .rx_valid(rx_valid),
        .rx_data(rx_data), .busy(busy), .set_done(set_done),
        .set_err(set_err), .st(st), .ph(ph), .in_ack(in_ack),
        .kind(kind), .bit_out(bit_out), .rd_ack(rd_ack)
    );

    i2c_seq_line u_line (
        .st(st), .ph(ph), .in_ack(in_ack), .kind(kind),
        .bit_out(bit_out), .rd_ack(rd_ack),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    i2c_seq_stat u_stat (
        .clk(clk), .rst_n(rst_n), .set_done(set_done), .set_err(set_err),
        .stat_clr(stat_clr), .irq_en(irq_en), .status(status),
        .res_code(res_code), .irq(irq)
    );
endmodule

// File: rtl/i2c_xact_seq_chk.sv
module i2c_xact_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [LEN_W-1:0] len_pri,
    input logic [2:0]       stat_clr,
    input logic             tx_pop,
    input logic             rx_valid,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic [2:0]       status
);
    // R6
    idle_lines_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R4
    zero_len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && len_pri == '0) |=> !busy);

    // R1
    pop_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> busy);

    // R2
    rx_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !stat_clr[0]) |=> status[0]);

    // R5
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(status[0]) && $rose(status[1])));
endmodule

bind i2c_xact_seq i2c_xact_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .len_pri(len_pri),
    .stat_clr(stat_clr), .tx_pop(tx_pop), .rx_valid(rx_valid),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .status(status)
);

// File: tb/i2c_xact_seq_bench.sv
module i2c_xact_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int MAX_CYC    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       go = 1'b0, rd_sel = 1'b0, dir_chg_en = 1'b0;
    logic [6:0] tgt_addr = '0;
    logic [7:0] len_pri = '0, len_aux = '0;
    logic [1:0] xact_cnt = '0;
    logic [2:0] irq_en = '0, stat_clr = '0;
    logic [7:0] tx_data, rx_data;
    logic       tx_pop, rx_valid, sda_in, scl_oe, sda_oe, busy, irq;
    logic [2:0] status;
    logic [1:0] res_code;

    i2c_xact_seq u_i2c_xact_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .rd_sel(rd_sel),
        .tgt_addr(tgt_addr), .len_pri(len_pri), .len_aux(len_aux),
        .xact_cnt(xact_cnt), .dir_chg_en(dir_chg_en), .irq_en(irq_en),
        .stat_clr(stat_clr), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .status(status),
        .res_code(res_code), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";
    logic [9:0] exp_q[$];

    function automatic logic [7:0] txv(int i);
        return 8'(8'h31 + i * 7);
    endfunction
    function automatic logic [7:0] rdv(int i);
        return 8'(8'hC5 ^ (i * 29));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard compare: tag 0 = byte seen by target, 1 = rx byte, 2 = master ack bit
    task automatic sb_cmp(logic [1:0] tag, logic [7:0] val);
        n_chk++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected none", cur_req, {tag, val});
        end else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            if (e != {tag, val}) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", cur_req, {tag, val}, e);
            end
        end
    endtask

    // tick generator and TX source
    int tdiv = 0, tx_idx = 0, pops = 0;
    always @(posedge clk) begin
        tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TICK_DIV - 1);
        if (tx_pop) begin
            tx_idx <= tx_idx + 1;
            pops   <= pops + 1;
        end
    end
    assign tx_data = txv(tx_idx);

    // target model on the open-drain lines
    logic scl_l, sda_l, scl_p, sda_p, slv_pull, is_addr, tx_act;
    logic [7:0] sh, txb;
    int bitcnt, rxc, ri = 0, starts = 0, stops = 0, nack_at = 99;
    assign scl_l  = !scl_oe;
    assign sda_l  = !(sda_oe || slv_pull);
    assign sda_in = sda_l;

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1; sda_p <= 1'b1; slv_pull <= 1'b0;
            is_addr <= 1'b0; tx_act <= 1'b0; bitcnt <= 0; rxc <= 0;
            sh <= '0; txb <= '0;
        end else begin
            scl_p <= scl_l;
            sda_p <= sda_l;
            if (scl_l && scl_p && sda_p && !sda_l) begin
                bitcnt <= 0; is_addr <= 1'b1; tx_act <= 1'b0; rxc <= 0;
                starts <= starts + 1;
            end else if (scl_l && scl_p && !sda_p && sda_l) begin
                stops <= stops + 1; tx_act <= 1'b0;
            end else if (scl_l && !scl_p) begin
                if (bitcnt < 8) begin
                    if (is_addr || !tx_act) sh <= {sh[6:0], sda_l};
                    bitcnt <= bitcnt + 1;
                end else begin
                    bitcnt <= 0;
                    if (is_addr || !tx_act) begin
                        sb_cmp(2'd0, sh);
                        rxc <= rxc + 1;
                        if (is_addr) begin
                            is_addr <= 1'b0;
                            if (sh[0] && rxc != nack_at) begin
                                tx_act <= 1'b1; txb <= rdv(ri); ri <= ri + 1;
                            end
                        end
                    end else begin
                        sb_cmp(2'd2, {7'b0, sda_l});
                        if (!sda_l) begin txb <= rdv(ri); ri <= ri + 1; end
                        else tx_act <= 1'b0;
                    end
                end
            end else if (!scl_l && scl_p) begin
                if (bitcnt == 8) slv_pull <= (is_addr || !tx_act) ? (rxc != nack_at) : 1'b0;
                else             slv_pull <= tx_act ? !txb[7 - bitcnt] : 1'b0;
            end
        end
    end

    // monitor of the RX sink
    always @(negedge clk) if (rst_n && rx_valid) sb_cmp(2'd1, rx_data);

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == MAX_CYC) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, MAX_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    int etx = 0, erd = 0;
    task automatic push(logic [1:0] tag, logic [7:0] v);
        exp_q.push_back({tag, v});
    endtask
    task automatic exp_wr(logic [6:0] a, int n);
        push(2'd0, {a, 1'b0});
        for (int i = 0; i < n; i++) push(2'd0, txv(etx + i));
        etx += n;
    endtask
    task automatic exp_rd(logic [6:0] a, int n);
        push(2'd0, {a, 1'b1});
        for (int i = 0; i < n; i++) begin
            push(2'd2, {7'b0, i == n - 1});
            push(2'd1, rdv(erd + i));
        end
        erd += n;
    endtask

    task automatic run(logic rd, logic [6:0] a, int lp, int la, int xc, logic dce);
        @(negedge clk);
        rd_sel = rd; tgt_addr = a; len_pri = 8'(lp); len_aux = 8'(la);
        xact_cnt = 2'(xc); dir_chg_en = dce; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask
    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask
    task automatic clr(logic [2:0] m);
        @(negedge clk); stat_clr = m;
        @(negedge clk); stat_clr = '0;
    endtask

    int s0, p0, t0;
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset busy", busy, 0);
        chk("R7 reset status", status, 0);
        chk("R8 reset irq", irq, 0);
        chk("R9 reset code", res_code, 0);
        chk("R6 reset lines", {scl_oe, sda_oe}, 0);

        // R1 plain write of 3 bytes
        cur_req = "R1"; s0 = starts; t0 = stops; p0 = pops;
        exp_wr(7'h2A, 3);
        run(1'b0, 7'h2A, 3, 0, 1, 1'b0);
        chk("R6 busy after go", busy, 1);
        wait_idle();
        chk("R6 lines released at idle", {scl_oe, sda_oe}, 0);
        chk("R1 status done", status, 3'b001);
        chk("R1 pops", pops - p0, 3);
        chk("R1 start/stop", (starts - s0) * 16 + (stops - t0), 17);
        chk("R1 queue drained", exp_q.size(), 0);
        chk("R9 code done", res_code, 1);

        // R8 interrupt enables
        @(negedge clk); irq_en = 3'b001; #2;
        chk("R8 irq enabled", irq, 1);
        @(negedge clk); irq_en = 3'b110; #2;
        chk("R8 irq masked", irq, 0);
        irq_en = 3'b000;

        // R7 clear
        clr(3'b001);
        chk("R7 cleared", status, 0);
        chk("R9 code none", res_code, 0);

        // R2 plain read of 2 bytes
        cur_req = "R2"; s0 = starts; t0 = stops;
        exp_rd(7'h11, 2);
        run(1'b1, 7'h11, 2, 0, 1, 1'b0);
        wait_idle();
        chk("R2 status done", status, 3'b001);
        chk("R2 start/stop", (starts - s0) * 16 + (stops - t0), 17);
        chk("R2 queue drained", exp_q.size(), 0);
        clr(3'b111);

        // R3 combined write 2 then read 3
        cur_req = "R3"; s0 = starts; t0 = stops; p0 = pops;
        exp_wr(7'h50, 2);
        exp_rd(7'h50, 3);
        run(1'b0, 7'h50, 2, 3, 2, 1'b1);
        wait_idle();
        chk("R3 status done", status, 3'b001);
        chk("R3 repeated start, single stop", (starts - s0) * 16 + (stops - t0), 33);
        chk("R3 pops", pops - p0, 2);
        chk("R3 queue drained", exp_q.size(), 0);
        clr(3'b001);

        // R3 count of 2 without direction change: plain write
        cur_req = "R3"; s0 = starts; t0 = stops;
        exp_wr(7'h33, 2);
        run(1'b0, 7'h33, 2, 4, 2, 1'b0);
        wait_idle();
        chk("R3 no dir change is single", (starts - s0) * 16 + (stops - t0), 17);
        chk("R3 single queue drained", exp_q.size(), 0);
        clr(3'b001);

        // R4 zero lengths
        cur_req = "R4"; s0 = starts;
        run(1'b0, 7'h12, 0, 2, 1, 1'b0);
        chk("R4 zero primary not busy", busy, 0);
        run(1'b0, 7'h12, 2, 0, 2, 1'b1);
        chk("R4 zero aux not busy", busy, 0);
        repeat (40) @(negedge clk);
        chk("R4 lines idle", {scl_oe, sda_oe}, 0);
        chk("R4 no start", starts - s0, 0);
        chk("R4 status unchanged", status, 0);

        // R5 NACK on address
        cur_req = "R5"; nack_at = 0; p0 = pops; t0 = stops;
        push(2'd0, {7'h44, 1'b0});
        run(1'b0, 7'h44, 3, 0, 1, 1'b0);
        wait_idle();
        chk("R5 addr nack status", status, 3'b010);
        chk("R5 addr nack no pops", pops - p0, 0);
        chk("R5 addr nack stop", stops - t0, 1);
        chk("R9 code ackerr", res_code, 2);
        clr(3'b010);

        // R5 NACK on second write byte, with done already set for R9
        cur_req = "R5"; nack_at = 99;
        exp_wr(7'h21, 1);
        run(1'b0, 7'h21, 1, 0, 1, 1'b0);
        wait_idle();
        nack_at = 2; p0 = pops;
        push(2'd0, {7'h21, 1'b0});
        push(2'd0, txv(etx)); push(2'd0, txv(etx + 1)); etx += 2;
        run(1'b0, 7'h21, 4, 0, 1, 1'b0);
        wait_idle();
        chk("R5 data nack pops", pops - p0, 2);
        chk("R5 data nack queue drained", exp_q.size(), 0);
        chk("R9 both bits set", status, 3'b011);
        chk("R9 ackerr outranks done", res_code, 2);
        @(negedge clk); irq_en = 3'b010; #2;
        chk("R8 irq on ackerr", irq, 1);
        irq_en = '0;
        clr(3'b010);
        chk("R7 selective clear", status, 3'b001);
        clr(3'b001);
        nack_at = 99;

        // R6 start strobe while busy is ignored
        cur_req = "R6"; s0 = starts; p0 = pops;
        exp_wr(7'h0F, 2);
        run(1'b0, 7'h0F, 2, 0, 1, 1'b0);
        repeat (30) @(negedge clk);
        chk("R6 busy mid transfer", busy, 1);
        run(1'b1, 7'h70, 5, 0, 1, 1'b0);
        wait_idle();
        @(negedge clk);
        chk("R6 late go ignored: busy", busy, 0);
        chk("R6 late go ignored: starts", starts - s0, 1);
        chk("R6 late go ignored: pops", pops - p0, 2);
        chk("R6 queue drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule